// File: doc/BRIEF.md
# Handshake-Gated SPI Master

This block is a single-channel SPI master whose transfers are paced by a ready line from the attached slave. A word offered on the transmit stream is taken only while the block is idle and the synchronized ready line is high. The block then drives slave-select low, waits a fixed lead time, sends between 1 and 32 bits on SCLK, waits a fixed lag time and releases slave-select. It then holds slave-select high for a programmable minimum gap before it takes the next word.

SCLK runs at a programmable division of the system clock and idles low. The transmit word leaves most significant bit first. The received word is presented together with a one-cycle done pulse. The inter-transfer gap counts either whole SCLK periods or rising edges of a slow 32.768 kHz clock. That slow clock is brought in asynchronously and turned into a synchronized tick before it is counted.

The transmit stream follows valid/ready rules. `tx_ready` is high only while the block is idle and the synchronized ready line is high. A word moves on a clock edge where `tx_valid` and `tx_ready` are both high. Holding `tx_valid` low stalls the block in idle with no time limit, and a valid word with `tx_ready` low waits unchanged. Clock divider, bit count and wait settings are captured at the accepting edge and stay fixed for that transfer and the gap that follows it.

Top module: `spi_rdy_master`

## Requirements
- R1: After reset `ss_n` is 1 and `sclk`, `mosi`, `done` and `tx_ready` are 0.
- R2: `rdy_in` passes through a two-stage synchronizer. Slave-select never falls earlier than 2 system clocks after `rdy_in` rises. When idle with `tx_valid` high, `ss_n` falls exactly 3 clocks after `rdy_in` rises, and it falls on every edge where `tx_valid` and `tx_ready` are both high.
- R3: One SCLK period is 2*(`clk_div`+1) system clocks. The first rising SCLK edge comes exactly 3 SCLK periods after `ss_n` falls.
- R4: Each transfer has exactly N rising SCLK edges. N is `bit_count`, and the code 0 means 32. `mosi` carries `tx_data[N-1]` down to `tx_data[0]`, changes only at rising SCLK edges and is stable at falling edges. SCLK is high only while `ss_n` is low.
- R5: `miso` is sampled at each falling SCLK edge. The first bit received lands in `rx_data[N-1]`, the last in `rx_data[0]`, and the bits above N-1 read 0.
- R6: `ss_n` rises exactly 2 SCLK periods after the last falling SCLK edge.
- R7: `done` is high for exactly one clock, in the cycle in which `ss_n` has just risen, and `rx_data` holds the received word at that time.
- R8: With `wait_on_slow` = 0 and W = `wait_count`, slave-select stays high for at least one SCLK period plus W SCLK periods. When ready and a valid word are already present, the next fall comes exactly 2*(`clk_div`+1)*(1+W)+1 clocks after the rise.
- R9: With `wait_on_slow` = 1, the gap is one SCLK period followed by W synchronized rising edges of `slow_clk_in`, and then one clock to accept the next word.
- R10: Once `ss_n` is high, `rdy_in` may fall at any time. No new transfer starts, `tx_ready` stays 0 and a waiting word stays unused until `rdy_in` is again seen high through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_in | input | 1 | Asynchronous ready handshake from the slave |
| slow_clk_in | input | 1 | Asynchronous 32.768 kHz clock used as the slow wait unit |
| clk_div | input | DIVW (8) | SCLK half period minus one, in system clocks |
| bit_count | input | BCW (5) | Bits per transfer, 0 means MAXB |
| wait_count | input | WAITW (8) | Number of gap units after the minimum gap |
| wait_on_slow | input | 1 | Gap unit: 0 = SCLK period, 1 = slow clock period |
| tx_data | input | MAXB (32) | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Block idle and ready line high |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Slave select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| rx_data | output | MAXB (32) | Received word, right-aligned |
| done | output | 1 | One-clock pulse when slave-select is released |

## Verification
The hardest situation to reach from the ports is a ready line that drops right after slave-select is released while a word is already waiting. In that case the synchronizer delay, the gap counter and the idle check interact. The stimulus releases ready in the cycle the release is seen and keeps `tx_valid` high for longer than the gap. It then watches slave-select and `tx_ready` stay inactive before ready comes back. Gaps counted in slow-clock edges have a phase that cannot be controlled, so they are checked against a window, while bit-clock gaps are checked to the exact cycle over random dividers, widths and wait counts.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_LAG,
    ST_GAP,
    ST_WAIT
  } spi_rdy_state_e;

  // interval lengths in SCLK half periods
  localparam int LEAD_HALVES = 6;
  localparam int LAG_HALVES  = 4;
  localparam int GAP_HALVES  = 2;

endpackage

// File: rtl/spi_rdy_sync.sv
module spi_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rdy_halfclk.sv
module spi_rdy_halfclk #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            half_tick
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign half_tick = en && (cnt == div);
endmodule

// File: rtl/spi_rdy_shift.sv
module spi_rdy_shift #(
  parameter int MAXB = 32,
  parameter int NBW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXB-1:0] tx_word,
  input  logic [NBW-1:0]  nbits,
  input  logic            rise,
  input  logic            fall,
  input  logic            capture,
  input  logic            miso,
  output logic            mosi,
  output logic [MAXB-1:0] rx_word
);
  logic [MAXB-1:0] tx_sh;
  logic [MAXB-1:0] rx_sh;
  logic [NBW-1:0]  pad;

  assign pad = NBW'(MAXB) - nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      mosi  <= 1'b0;
    end else if (load) begin
      tx_sh <= tx_word << pad;
      rx_sh <= '0;
    end else begin
      if (rise) begin
        mosi  <= tx_sh[MAXB-1];
        tx_sh <= {tx_sh[MAXB-2:0], 1'b0};
      end
      if (fall) rx_sh <= {rx_sh[MAXB-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_word <= '0;
    else if (capture) rx_word <= rx_sh;
  end
endmodule

// File: rtl/spi_rdy_seq.sv
module spi_rdy_seq
  import spi_rdy_pkg::*;
#(
  parameter int DIVW  = 8,
  parameter int WAITW = 8,
  parameter int NBW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdy_s,
  input  logic             slow_tick,
  input  logic             half_tick,
  input  logic             tx_valid,
  input  logic [DIVW-1:0]  div_in,
  input  logic [NBW-1:0]   nbits_in,
  input  logic [WAITW-1:0] wait_in,
  input  logic             src_in,
  output logic             tx_ready,
  output logic             load,
  output logic             rise,
  output logic             fall,
  output logic             capture,
  output logic             clk_en,
  output logic [DIVW-1:0]  div_q,
  output logic             ss_n,
  output logic             sclk,
  output logic             done
);
  localparam int HW = NBW + 1;

  spi_rdy_state_e   st;
  logic [HW-1:0]    hcnt;
  logic [WAITW:0]   wcnt;
  logic [NBW-1:0]   nb_q;
  logic [WAITW-1:0] w_q;
  logic             src_q;
  logic [WAITW:0]   wait_target;
  logic             wait_evt;
  logic             last_half;
  logic             lead_end, lag_end, gap_end;

  assign tx_ready    = (st == ST_IDLE) && rdy_s;
  assign load        = tx_ready && tx_valid;
  assign clk_en      = (st != ST_IDLE);
  assign wait_target = src_q ? {1'b0, w_q} : {w_q, 1'b0};
  assign wait_evt    = src_q ? slow_tick : half_tick;
  assign last_half   = (hcnt == ({nb_q, 1'b0} - HW'(2)));
  assign lead_end    = (hcnt == HW'(LEAD_HALVES - 1));
  assign lag_end     = (hcnt == HW'(LAG_HALVES - 1));
  assign gap_end     = (hcnt == HW'(GAP_HALVES - 1));
  assign rise        = half_tick && (((st == ST_LEAD) && lead_end) ||
                                     ((st == ST_SHIFT) && !sclk));
  assign fall        = half_tick && (st == ST_SHIFT) && sclk;
  assign capture     = half_tick && (st == ST_LAG) && lag_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      hcnt  <= '0;
      wcnt  <= '0;
      nb_q  <= '0;
      w_q   <= '0;
      src_q <= 1'b0;
      div_q <= '0;
      ss_n  <= 1'b1;
      sclk  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            st    <= ST_LEAD;
            ss_n  <= 1'b0;
            hcnt  <= '0;
            nb_q  <= nbits_in;
            w_q   <= wait_in;
            src_q <= src_in;
            div_q <= div_in;
          end
        end
        ST_LEAD: begin
          if (half_tick) begin
            if (lead_end) begin
              st   <= ST_SHIFT;
              sclk <= 1'b1;
              hcnt <= '0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (half_tick) begin
            sclk <= ~sclk;
            if (last_half) begin
              st   <= ST_LAG;
              hcnt <= '0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        ST_LAG: begin
          if (half_tick) begin
            if (lag_end) begin
              st   <= ST_GAP;
              ss_n <= 1'b1;
              done <= 1'b1;
              hcnt <= '0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (half_tick) begin
            if (gap_end) begin
              wcnt <= '0;
              st   <= (wait_target == '0) ? ST_IDLE : ST_WAIT;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (wait_evt) begin
            if (wcnt == wait_target - 1'b1) st <= ST_IDLE;
            else                            wcnt <= wcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_rdy_master.sv
module spi_rdy_master #(
  parameter int MAXB        = 32,
  parameter int DIVW        = 8,
  parameter int WAITW       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BCW         = $clog2(MAXB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdy_in,
  input  logic             slow_clk_in,
  input  logic [DIVW-1:0]  clk_div,
  input  logic [BCW-1:0]   bit_count,
  input  logic [WAITW-1:0] wait_count,
  input  logic             wait_on_slow,
  input  logic [MAXB-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             miso,
  output logic             ss_n,
  output logic             sclk,
  output logic             mosi,
  output logic [MAXB-1:0]  rx_data,
  output logic             done
);
  localparam int NBW = BCW + 1;

  logic            rdy_s;
  logic            slow_s;
  logic            slow_prev;
  logic            slow_tick;
  logic            half_tick;
  logic            clk_en;
  logic [DIVW-1:0] div_q;
  logic            load, rise, fall, capture;
  logic [NBW-1:0]  nbits;

  assign nbits = (bit_count == '0) ? NBW'(MAXB) : {1'b0, bit_count};

  spi_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
  );

  spi_rdy_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk(clk), .rst_n(rst_n), .d(slow_clk_in), .q(slow_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_prev <= 1'b0;
    else        slow_prev <= slow_s;
  end
  assign slow_tick = slow_s && !slow_prev;

  spi_rdy_halfclk #(.DIVW(DIVW)) u_halfclk (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .div(div_q), .half_tick(half_tick)
  );

  spi_rdy_seq #(.DIVW(DIVW), .WAITW(WAITW), .NBW(NBW)) u_seq (
    .clk(clk), .rst_n(rst_n), .rdy_s(rdy_s), .slow_tick(slow_tick),
    .half_tick(half_tick), .tx_valid(tx_valid), .div_in(clk_div),
    .nbits_in(nbits), .wait_in(wait_count), .src_in(wait_on_slow),
    .tx_ready(tx_ready), .load(load), .rise(rise), .fall(fall),
    .capture(capture), .clk_en(clk_en), .div_q(div_q), .ss_n(ss_n),
    .sclk(sclk), .done(done)
  );

  spi_rdy_shift #(.MAXB(MAXB), .NBW(NBW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .tx_word(tx_data), .nbits(nbits),
    .rise(rise), .fall(fall), .capture(capture), .miso(miso), .mosi(mosi),
    .rx_word(rx_data)
  );
endmodule

// File: rtl/spi_rdy_master_chk.sv
module spi_rdy_master_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_in,
  input logic tx_valid,
  input logic tx_ready,
  input logic ss_n,
  input logic sclk,
  input logic mosi,
  input logic done
);
  // R2: slave-select only falls after ready was seen three samples earlier
  p_ss_after_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(rdy_in, 3));

  // R2: an accepted word starts the frame on the same edge
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> $fell(ss_n));

  // R4: clock pulses stay inside the frame
  p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);

  // R4: data does not move at a sampling edge
  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(mosi));

  // R7: done marks the release of slave-select
  p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ss_n));

  // R7: done lasts one clock
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: the stream is offered only while slave-select is inactive
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ss_n);
endmodule

bind spi_rdy_master spi_rdy_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_in(rdy_in), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .done(done)
);

// File: tb/spi_rdy_master_test.sv
`timescale 1ns/1ps
module spi_rdy_master_test;
  localparam int MAXB = 32;
  localparam int SP   = 20; // slow clock period in system clocks

  logic        clk = 1'b0, rst_n = 1'b0, rdy = 1'b0, slow = 1'b0;
  logic [7:0]  clk_div = '0;
  logic [4:0]  bit_count = '0;
  logic [7:0]  wait_count = '0;
  logic        wait_on_slow = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        miso = 1'b0;
  logic        tx_ready, ss_n, sclk, mosi, done;
  logic [31:0] rx_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  initial begin #1; forever #40 slow = ~slow; end

  spi_rdy_master uut (
    .clk(clk), .rst_n(rst_n), .rdy_in(rdy), .slow_clk_in(slow),
    .clk_div(clk_div), .bit_count(bit_count), .wait_count(wait_count),
    .wait_on_slow(wait_on_slow), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .miso(miso), .ss_n(ss_n), .sclk(sclk),
    .mosi(mosi), .rx_data(rx_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  // expectations set by the driver
  int e_n = 8, e_h = 1, e_w = 0, e_src = 0; bit e_gapchk = 0;
  logic [31:0] e_tx = '0, e_s = '0;
  bit rdy_arm = 0; longint t_rdy = 0;

  // monitor state
  int cyc = 0, n_end = 0;
  logic p_ss = 1'b1, p_sclk = 1'b0;
  int m_n, m_h, m_w, m_src; bit m_gapchk; logic [31:0] m_tx, m_s, m_mo;
  int t_fall, t_rise, t_lastfall, nrise;
  int g_h, g_w, g_src; bit g_chk = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!ss_n && p_ss) begin
        t_fall = cyc;
        if (rdy_arm) begin
          chk(($time - t_rdy) == 12, "R2", "rdy to ss fall ns", $time - t_rdy, 12);
          rdy_arm = 0;
        end
        if (g_chk) begin
          if (g_src == 0)
            chk((cyc - t_rise) == 2*g_h*(1+g_w)+1, "R8", "gap clocks",
                cyc - t_rise, 2*g_h*(1+g_w)+1);
          else
            chk((cyc - t_rise) >= 2*g_h+(g_w-1)*SP+1 && (cyc - t_rise) <= 2*g_h+g_w*SP+5,
                "R9", "slow gap clocks", cyc - t_rise, 2*g_h+g_w*SP);
          g_chk = 0;
        end
        m_n = e_n; m_h = e_h; m_w = e_w; m_src = e_src; m_gapchk = e_gapchk;
        m_tx = e_tx; m_s = e_s; m_mo = '0; nrise = 0;
      end
      if (sclk && !p_sclk) begin
        nrise++;
        if (nrise == 1)
          chk((cyc - t_fall) == 6*m_h, "R3", "lead clocks", cyc - t_fall, 6*m_h);
        if (nrise <= m_n) miso = m_s[m_n - nrise];
      end
      if (!sclk && p_sclk) begin
        m_mo = {m_mo[30:0], mosi};
        t_lastfall = cyc;
      end
      if (ss_n && !p_ss) begin
        t_rise = cyc;
        chk(nrise == m_n, "R4", "sclk pulses", nrise, m_n);
        chk(m_mo == (m_tx & mask_of(m_n)), "R4", "mosi word", m_mo, m_tx & mask_of(m_n));
        chk((cyc - t_lastfall) == 4*m_h, "R6", "lag clocks", cyc - t_lastfall, 4*m_h);
        chk(done == 1'b1, "R7", "done at release", done, 1);
        chk(rx_data == (m_s & mask_of(m_n)), "R5", "rx word", rx_data, m_s & mask_of(m_n));
        g_h = m_h; g_w = m_w; g_src = m_src; g_chk = m_gapchk;
        n_end++;
      end else if (done) begin
        chk(0, "R7", "stray done", 1, 0);
      end
    end
    p_ss = ss_n; p_sclk = sclk;
  end

  task automatic setup(input int div, input int n, input logic [31:0] tx,
                       input logic [31:0] s, input int src, input int w, input bit gapchk);
    clk_div = 8'(div); bit_count = 5'(n); wait_count = 8'(w);
    wait_on_slow = 1'(src); tx_data = tx;
    e_n = n; e_h = div + 1; e_w = w; e_src = src; e_tx = tx; e_s = s; e_gapchk = gapchk;
    tx_valid = 1'b1;
  endtask

  task automatic finish_xfer();
    int k = n_end;
    while (tx_ready !== 1'b1) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
    while (n_end == k) @(negedge clk);
  endtask

  task automatic xfer(input int div, input int n, input logic [31:0] tx,
                      input logic [31:0] s, input int src, input int w, input bit gapchk);
    @(negedge clk);
    setup(div, n, tx, s, src, w, gapchk);
    finish_xfer();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ss_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && done == 1'b0 && tx_ready == 1'b0,
        "R1", "reset outputs", {ss_n, sclk, mosi, done, tx_ready}, 5'b10000);
    rst_n = 1'b1;
    // R10: word offered with ready low is left alone
    @(negedge clk);
    setup(1, 8, 32'hA5, 32'h3C, 0, 0, 1);
    begin
      int bad = 0;
      repeat (12) begin @(negedge clk); if (!ss_n || tx_ready) bad++; end
      chk(bad == 0, "R10", "idle without ready", bad, 0);
    end
    // R2: exact ready to select latency
    rdy = 1'b1; t_rdy = $time; rdy_arm = 1;
    finish_xfer();
    // corner widths
    xfer(0, 32, 32'h8000_0001, 32'hC3A5_5A3C, 0, 0, 1);
    xfer(0, 1, 32'h1, 32'h1, 0, 1, 1);
    xfer(2, 1, 32'h0, 32'h1, 0, 0, 1);
    // random bit-clock transfers
    for (int i = 0; i < 24; i++)
      xfer(int'($urandom_range(0, 3)), int'($urandom_range(1, 32)), $urandom, $urandom,
           0, int'($urandom_range(0, 3)), 1);
    // slow-clock gaps
    xfer(0, 8, $urandom, $urandom, 1, 2, 1);
    xfer(1, 16, $urandom, $urandom, 1, 3, 1);
    xfer(0, 5, $urandom, $urandom, 1, 1, 1);
    xfer(0, 12, $urandom, $urandom, 0, 0, 0);
    // R10: ready drops right after release
    xfer(1, 8, 32'h5A, 32'hF0, 0, 3, 0);
    rdy = 1'b0;
    setup(1, 12, 32'hABC, 32'h123, 0, 0, 0);
    begin
      int bad = 0;
      repeat (40) begin @(negedge clk); if (!ss_n || tx_ready) bad++; end
      chk(bad == 0, "R10", "no start after ready drop", bad, 0);
    end
    rdy = 1'b1; t_rdy = $time; rdy_arm = 1;
    finish_xfer();
    repeat (10) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule